// File: doc/BRIEF.md
# Clock Multiplier Bring-Up Sequencer

This block drives the start-up of an on-chip clock multiplier from the host side. When start is pulsed, it captures the reference frequency (in kHz) and the three divider settings. These are the feedback multiplier M, the input divider N and the output divider P. It then proves, in integer arithmetic, that the comparison frequency fin/(N+1), the loop frequency fin·M/(N+1) and the output frequency fin·M/(2·(N+1)·(P+1)) all fall inside their legal windows. It also checks that M is at least 16.

A setting that passes is written to the multiplier's register file over a request/acknowledge write port, in a fixed order. The two divider registers are written first. The control register is then written to leave bypass set and clear power-down. The sequencer then waits out a settling interval and finally writes the control register to clear bypass. A setting that fails produces no write at all: the error flag is raised and the sequencer drops back to idle. The control register keeps its reset state, which is bypassed and powered down.

The settling interval is a cycle count derived from the parameter giving the sequencer clock's cycles per microsecond. It covers at least 151 µs.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, and after any reset during a run, busy, done, error and wr_req are all low.
- R2: A setting with M below 16 is rejected: error goes high, done stays low and no write is issued. M equal to 16 is accepted if the other windows hold.
- R3: A setting is rejected unless 2000·(N+1) ≤ fin_khz ≤ 16000·(N+1), with both bounds inclusive.
- R4: A setting is rejected unless 110000·(N+1) ≤ fin_khz·M ≤ 220000·(N+1), with both bounds inclusive.
- R5: A setting is rejected unless 72000·(N+1)·(P+1) ≤ fin_khz·M ≤ 80000·(N+1)·(P+1), which means an output of 36 to 40 MHz inclusive.
- R6: An accepted setting produces exactly four writes, in this order. First, address DIVA_ADDR (default 0x66) with data M in bits 15:8 and N in bits 5:0. Second, DIVB_ADDR (default 0x67) with data P in bits 6:0. Third, CTRL_ADDR (default 0x65) with data 0x8000, where bit 15 is bypass and stays set, and bit 14 is power-down and is cleared. Fourth, CTRL_ADDR with data 0x0000. All other bits are zero.
- R7: While wr_req is high and wr_ack has not been seen, wr_req, wr_addr and wr_data hold. A write completes on the clock edge where wr_req and wr_ack are both high, and only then does the next step begin.
- R8: The bypass-clearing write is not requested until at least SETTLE_US·CYC_PER_US cycles after the power-up write was acknowledged, with SETTLE_US defaulting to 151.
- R9: After the last acknowledge, busy falls and done rises with error low. done and error hold until the next accepted start.
- R10: A start pulse while busy is high is ignored. The run in progress completes with its original settings and issues no extra writes.
- R11: On a rejected setting, busy falls within two cycles of start, error rises, and wr_req stays low for the whole run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle |
| fin_khz | input | FIN_W | Reference frequency in kHz |
| m_val | input | M_W | Feedback multiplier M |
| n_val | input | N_W | Input divider N |
| p_val | input | P_W | Output divider P |
| wr_ack | input | 1 | Write acknowledge from the register port |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed successfully |
| error | output | 1 | Last sequence rejected by the range check |

## Verification
The hardest situation to reach from the ports is a setting that breaks exactly one window while it sits on the edge of the others. Many illegal settings break two windows at once, so they would hide a faulty single check. The stimulus table was therefore built by hand. One group of vectors lands exactly on each inclusive bound. Another group violates a single window while the other windows and the M limit hold. For example, one vector has a legal output frequency but a loop frequency below 110 MHz. A second hard case is a start pulse that arrives during the settling wait. The bench waits until the power-up write has been acknowledged and then drives start with different settings, so the write log can show that those settings were ignored.

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq #(
  parameter int FIN_W      = 16,
  parameter int M_W        = 8,
  parameter int N_W        = 6,
  parameter int P_W        = 7,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int CYC_PER_US = 4,
  parameter int SETTLE_US  = 151,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h65,
  parameter logic [ADDR_W-1:0] DIVA_ADDR = 8'h66,
  parameter logic [ADDR_W-1:0] DIVB_ADDR = 8'h67
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FIN_W-1:0]  fin_khz,
  input  logic [M_W-1:0]    m_val,
  input  logic [N_W-1:0]    n_val,
  input  logic [P_W-1:0]    p_val,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int CW         = $clog2(SETTLE_CYC + 1);
  localparam int PW         = 48;
  localparam int BYP_BIT    = DATA_W - 1;
  localparam int M_LSB      = 8;
  localparam logic [DATA_W-1:0] CTRL_PWRUP = DATA_W'(1) << BYP_BIT;
  localparam logic [DATA_W-1:0] CTRL_RUN   = '0;
  localparam int M_MIN      = 16;
  localparam int PFD_LO     = 2000;
  localparam int PFD_HI     = 16000;
  localparam int VCO_LO     = 110000;
  localparam int VCO_HI     = 220000;
  localparam int OUT_LO2    = 72000;
  localparam int OUT_HI2    = 80000;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_DIVA, S_DIVB, S_PWRUP, S_SETTLE, S_RELEASE
  } st_t;

  st_t              st;
  logic [FIN_W-1:0] fin_q;
  logic [M_W-1:0]   m_q;
  logic [N_W-1:0]   n_q;
  logic [P_W-1:0]   p_q;
  logic [CW-1:0]    cnt;
  logic             done_q, err_q;

  logic [PW-1:0] n1, p1, np, fin_w, prod;
  logic          m_ok, pfd_ok, vco_ok, out_ok, cfg_ok;

  assign n1     = PW'(n_q) + PW'(1);
  assign p1     = PW'(p_q) + PW'(1);
  assign np     = n1 * p1;
  assign fin_w  = PW'(fin_q);
  assign prod   = fin_w * PW'(m_q);
  assign m_ok   = PW'(m_q) >= PW'(M_MIN);
  assign pfd_ok = (fin_w >= PW'(PFD_LO) * n1) && (fin_w <= PW'(PFD_HI) * n1);
  assign vco_ok = (prod >= PW'(VCO_LO) * n1) && (prod <= PW'(VCO_HI) * n1);
  assign out_ok = (prod >= PW'(OUT_LO2) * np) && (prod <= PW'(OUT_HI2) * np);
  assign cfg_ok = m_ok && pfd_ok && vco_ok && out_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      fin_q  <= '0;
      m_q    <= '0;
      n_q    <= '0;
      p_q    <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          fin_q  <= fin_khz;
          m_q    <= m_val;
          n_q    <= n_val;
          p_q    <= p_val;
          done_q <= 1'b0;
          err_q  <= 1'b0;
          st     <= S_CHECK;
        end
        S_CHECK: if (cfg_ok) st <= S_DIVA;
                 else begin
                   err_q <= 1'b1;
                   st    <= S_IDLE;
                 end
        S_DIVA:  if (wr_ack) st <= S_DIVB;
        S_DIVB:  if (wr_ack) st <= S_PWRUP;
        S_PWRUP: if (wr_ack) begin
          cnt <= '0;
          st  <= S_SETTLE;
        end
        S_SETTLE: if (cnt == CW'(SETTLE_CYC - 1)) st <= S_RELEASE;
                  else cnt <= cnt + CW'(1);
        S_RELEASE: if (wr_ack) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_addr = CTRL_ADDR;
    wr_data = CTRL_RUN;
    case (st)
      S_DIVA:  begin
        wr_addr = DIVA_ADDR;
        wr_data = (DATA_W'(m_q) << M_LSB) | DATA_W'(n_q);
      end
      S_DIVB:  begin
        wr_addr = DIVB_ADDR;
        wr_data = DATA_W'(p_q);
      end
      S_PWRUP: wr_data = CTRL_PWRUP;
      default: ;
    endcase
  end

  assign wr_req = (st == S_DIVA) || (st == S_DIVB) || (st == S_PWRUP) || (st == S_RELEASE);
  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign error  = err_q;
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int SETTLE_CYC = 604,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h65
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wr_ack,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              done,
  input logic              error
);
  localparam int BYP = DATA_W - 1;
  localparam int PD  = DATA_W - 2;

  logic        pu_seen;
  int unsigned since_pu;
  logic        pu_ack, rel_req;

  assign pu_ack  = wr_req && wr_ack && (wr_addr == CTRL_ADDR) && wr_data[BYP] && !wr_data[PD];
  assign rel_req = wr_req && (wr_addr == CTRL_ADDR) && !wr_data[BYP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_seen  <= 1'b0;
      since_pu <= 0;
    end else if (start && !busy) begin
      pu_seen  <= 1'b0;
    end else if (pu_ack) begin
      pu_seen  <= 1'b1;
      since_pu <= 0;
    end else if (since_pu != 32'hFFFF_FFFF) begin
      since_pu <= since_pu + 1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_req);

  // R7
  hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R8
  settle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req |-> (pu_seen && since_pu >= SETTLE_CYC));

  // R9
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && !error));

  // R11
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !wr_req);

  // R11
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> !busy);
endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .SETTLE_CYC(SETTLE_US * CYC_PER_US), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_ack(wr_ack),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .done(done), .error(error)
);

// File: tb/pll_bringup_seq_tb.sv
module pll_bringup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int SETTLE     = 151 * CPU;
  localparam int NV         = 11;

  localparam int VFIN [NV] = '{24000, 24000, 10000, 10000, 3900, 4000, 10000, 10000, 9000, 8999, 5000};
  localparam int VM   [NV] = '{20,    20,    15,    16,    75,   75,   23,    22,    16,   16,   16};
  localparam int VN   [NV] = '{2,     2,     0,     0,     1,    1,    0,     0,     0,    0,    0};
  localparam int VP   [NV] = '{1,     0,     1,     1,     1,    1,    2,     2,     1,    1,    0};
  localparam int VOK  [NV] = '{1,     0,     0,     1,     0,    1,    0,     1,     1,    0,    0};
  localparam string VTAG [NV] = '{"R6", "R5", "R2", "R2", "R3", "R3", "R4", "R4", "R5", "R5", "R4"};

  logic        clk = 0, rst_n = 0, start = 0, wr_ack = 0;
  logic [15:0] fin_khz = 0;
  logic [7:0]  m_val = 0;
  logic [5:0]  n_val = 0;
  logic [6:0]  p_val = 0;
  logic        wr_req, busy, done, error;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int checks = 0, fails = 0, nw = 0, cyc = 0, ack_lat = 0, wc = 0, moved = 0;
  logic [7:0]  wl_addr [8];
  logic [15:0] wl_data [8];
  int          wl_first [8], wl_ack [8];
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_bringup_seq #(.CYC_PER_US(CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fin_khz(fin_khz),
    .m_val(m_val), .n_val(n_val), .p_val(p_val), .wr_ack(wr_ack),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .error(error));

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      wr_ack = 0;
      if (!rst_n) wc = 0;
      else if (wr_req) begin
        if (wc == 0 && nw < 8) begin
          wl_addr[nw] = wr_addr; wl_data[nw] = wr_data; wl_first[nw] = cyc;
        end
        if (wc >= ack_lat) begin
          if (nw < 8) begin
            if (wr_addr != wl_addr[nw] || wr_data != wl_data[nw]) moved++;
            wl_ack[nw] = cyc;
            nw++;
          end
          wr_ack = 1;
          wc = 0;
        end else wc++;
      end else wc = 0;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic launch(input int f, input int m, input int n, input int p, input int lat);
    @(negedge clk);
    fin_khz = 16'(f); m_val = 8'(m); n_val = 6'(n); p_val = 7'(p);
    ack_lat = lat; nw = 0; moved = 0; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_writes(input string req, input int f, input int m, input int n, input int p);
    check(nw == 4, req, nw, 4);
    check(wl_addr[0] == 8'h66 && wl_data[0] == ((16'(m) << 8) | 16'(n)), req, wl_data[0], (m << 8) | n);
    check(wl_addr[1] == 8'h67 && wl_data[1] == 16'(p), req, wl_data[1], p);
    check(wl_addr[2] == 8'h65 && wl_data[2] == 16'h8000, req, wl_data[2], 16'h8000);
    check(wl_addr[3] == 8'h65 && wl_data[3] == 16'h0000, req, wl_data[3], 0);
    check(moved == 0, "R7", moved, 0);
    check(wl_first[3] - wl_ack[2] >= SETTLE, "R8", wl_first[3] - wl_ack[2], SETTLE);
    if (f < 0) check(1'b0, req, f, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error && !wr_req, "R1", {busy, done, error, wr_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !wr_req, "R1", {busy, wr_req}, 0);

    for (int i = 0; i < NV; i++) begin
      int t0;
      launch(VFIN[i], VM[i], VN[i], VP[i], i % 3);
      t0 = cyc;
      wait_idle();
      if (VOK[i] == 1) begin
        check(done && !error, VTAG[i], {done, error}, 2);
        check_writes("R6", VFIN[i], VM[i], VN[i], VP[i]);
      end else begin
        check(error && !done, VTAG[i], {done, error}, 1);
        check(nw == 0, "R11", nw, 0);
        check(cyc - t0 <= 2, "R11", cyc - t0, 2);
      end
    end

    // R9: done holds while idle
    launch(24000, 20, 2, 1, 1);
    wait_idle();
    repeat (6) @(negedge clk);
    check(done && !error && !busy, "R9", {busy, done, error}, 2);
    // R9: next accepted start clears done; a rejected one sets error
    launch(10000, 15, 0, 1, 0);
    wait_idle();
    check(!done && error, "R9", {done, error}, 1);
    repeat (4) @(negedge clk);
    check(error && !done, "R9", {done, error}, 1);

    // R10: start during settle is ignored
    launch(24000, 20, 2, 1, 0);
    while (nw < 3) @(negedge clk);
    repeat (5) @(negedge clk);
    fin_khz = 16'd10000; m_val = 8'd16; n_val = 6'd0; p_val = 7'd1; start = 1;
    @(negedge clk);
    start = 0;
    wait_idle();
    check(done && !error, "R10", {done, error}, 2);
    check_writes("R10", 24000, 20, 2, 1);
    repeat (4) @(negedge clk);
    check(!busy && nw == 4, "R10", nw, 4);

    // R1: reset in the middle of a run
    launch(24000, 20, 2, 1, 0);
    while (nw < 3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(!busy && !wr_req && !done && !error, "R1", {busy, wr_req, done, error}, 0);
    rst_n = 1;
    repeat (SETTLE + 10) @(negedge clk);
    check(nw == 3 && !wr_req && !busy, "R1", nw, 3);

    finish_run();
  end
endmodule